// File: doc/BRIEF.md
# Banked ROM Overlay Address Decoder

This block turns the address and write strobe of an 8-bit processor with a 16-bit address bus into chip selects for three memories: a RAM covering the lower half of the address space, a RAM covering the upper half, and an 8KB ROM that sits on top of the highest 8KB of the upper RAM. It also produces the active-low I/O request and memory request strobes. One 256-byte page, chosen by a parameter, is treated as I/O. Every other address is treated as memory.

A one-bit bank register decides whether the ROM can be seen. The register is set to 1 by reset, so the ROM is visible at start-up. While the bit is 1, reads from the top 8KB go to the ROM, but writes to that region still reach the RAM underneath. Start-up code can therefore copy vectors or routines into that RAM without being able to read it back. It then clears the bit through the write port, and after that the RAM answers reads in that region as well.

The selects are purely combinational in the address, the write strobe and the registered bank bit. The only clocked element is the bank register itself.

Top module: `rom_overlay_decoder`

## Requirements
- R1: `io_req_n` is low exactly when address bits 15..8 equal the parameter `IO_PAGE`. `mem_req_n` is always the inverse of `io_req_n`.
- R2: `rom_cs_n` is low exactly when all of these hold: address bits 15, 14 and 13 are all 1, `mem_req_n` is low, `cpu_wr_n` is 1 (a read), and the bank bit is 1.
- R3: `ram_hi_cs_n` is low exactly when address bit 15 is 1, `mem_req_n` is low and `rom_cs_n` is high. A write to the top 8KB therefore selects the upper RAM whatever the bank bit is.
- R4: `ram_lo_cs_n` is low exactly when address bit 15 is 0 and `mem_req_n` is low.
- R5: After reset the bank bit is 1, so a read of address 0xE000 asserts `rom_cs_n`.
- R6: When `bank_we` is 1 at a rising clock edge, the bank bit takes the value of `bank_wdata`, and the selects use the new value from that edge on. When `bank_we` is 0, changes on `bank_wdata` have no effect on any output.
- R7: At most one of `rom_cs_n`, `ram_hi_cs_n` and `ram_lo_cs_n` is low at any time. None of them is low while `io_req_n` is low.
- R8: When `IO_PAGE` lies inside the top 8KB (for example 0xF8), an access to that page asserts only `io_req_n`. Both the ROM select and the RAM selects stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank register |
| rst_n | input | 1 | Asynchronous active-low reset; sets the bank bit to 1 |
| cpu_addr | input | 16 | Processor address bus |
| cpu_wr_n | input | 1 | Active-low write strobe; high means read |
| bank_we | input | 1 | Write enable for the bank register |
| bank_wdata | input | 1 | New bank bit value; 1 makes the ROM visible |
| io_req_n | output | 1 | Active-low I/O request for the I/O page |
| mem_req_n | output | 1 | Active-low memory request; inverse of io_req_n |
| rom_cs_n | output | 1 | Active-low ROM chip select |
| ram_hi_cs_n | output | 1 | Active-low upper RAM chip select |
| ram_lo_cs_n | output | 1 | Active-low lower RAM chip select |

## Verification
The assertions assume that every cycle is a bus access. The block has no idle or strobe-qualified state, so the address and write strobe are always taken as valid. They also assume the inputs are stable around the sampling clock edge.

The stimulus follows both assumptions. It changes the address, the write strobe and the bank-port inputs only on the falling edge, and it checks the combinational outputs before the next rising edge. Bank writes are held across exactly one rising edge.

The sweep covers every address page with both strobe values and both bank values. It keeps `bank_wdata` at the opposite of the stored bit while `bank_we` is low. A second instance, with the I/O page placed inside the ROM window, sees the same stimulus.

// File: rtl/romdec_pkg.sv
package romdec_pkg;

    // Internal select vector, active high.
    typedef struct packed {
        logic rom;
        logic ram_hi;
        logic ram_lo;
    } cs_t;

    // State held by the bank register.
    typedef struct packed {
        logic bank_en;
    } bank_state_t;

    localparam logic BANK_RESET_VAL = 1'b1;

endpackage

// File: rtl/io_page_match.sv
module io_page_match #(
    parameter int               PAGE_W  = 8,
    parameter logic [PAGE_W-1:0] IO_PAGE = '0
) (
    input  logic [PAGE_W-1:0] page,
    output logic              io_hit
);
    // Compare each page bit with the constant, then AND the results together.
    logic [PAGE_W-1:0] bit_eq;

    for (genvar i = 0; i < PAGE_W; i++) begin : g_cmp
        assign bit_eq[i] = (page[i] == IO_PAGE[i]);
    end

    assign io_hit = &bit_eq;
endmodule

// File: rtl/bank_reg.sv
module bank_reg
    import romdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic wdata,
    output logic bank_en
);
    bank_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (we) begin
            state_d.bank_en = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.bank_en <= BANK_RESET_VAL;
        end else begin
            state_q <= state_d;
        end
    end

    assign bank_en = state_q.bank_en;
endmodule

// File: rtl/select_logic.sv
module select_logic
    import romdec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_n,
    input  logic              bank_en,
    input  logic              io_hit,
    output cs_t               sel
);
    localparam int HI = ADDR_W - 1;

    logic mem_acc;
    logic in_window;

    always_comb begin
        mem_acc    = !io_hit;
        in_window  = (&addr[HI -: WIN_W]) && mem_acc;
        sel.rom    = in_window && wr_n && bank_en;
        sel.ram_hi = addr[HI] && !sel.rom && mem_acc;
        sel.ram_lo = !addr[HI] && mem_acc;
    end
endmodule

// File: rtl/rom_overlay_decoder.sv
module rom_overlay_decoder
    import romdec_pkg::*;
#(
    parameter int               ADDR_W  = 16,
    parameter int               PAGE_W  = 8,
    parameter int               WIN_W   = 3,
    parameter logic [PAGE_W-1:0] IO_PAGE = 8'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr_n,
    input  logic              bank_we,
    input  logic              bank_wdata,
    output logic              io_req_n,
    output logic              mem_req_n,
    output logic              rom_cs_n,
    output logic              ram_hi_cs_n,
    output logic              ram_lo_cs_n
);
    localparam int HI = ADDR_W - 1;

    logic io_hit;
    logic bank_en;
    cs_t  sel;

    io_page_match #(
        .PAGE_W (PAGE_W),
        .IO_PAGE(IO_PAGE)
    ) u_io (
        .page  (cpu_addr[HI -: PAGE_W]),
        .io_hit(io_hit)
    );

    bank_reg u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bank_we),
        .wdata  (bank_wdata),
        .bank_en(bank_en)
    );

    select_logic #(
        .ADDR_W(ADDR_W),
        .WIN_W (WIN_W)
    ) u_sel (
        .addr   (cpu_addr),
        .wr_n   (cpu_wr_n),
        .bank_en(bank_en),
        .io_hit (io_hit),
        .sel    (sel)
    );

    assign io_req_n    = !io_hit;
    assign mem_req_n   = io_hit;
    assign rom_cs_n    = !sel.rom;
    assign ram_hi_cs_n = !sel.ram_hi;
    assign ram_lo_cs_n = !sel.ram_lo;
endmodule

// File: rtl/rom_overlay_decoder_chk.sv
module rom_overlay_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic        cpu_wr_n,
    input logic        bank_we,
    input logic        bank_wdata,
    input logic        io_req_n,
    input logic        mem_req_n,
    input logic        rom_cs_n,
    input logic        ram_hi_cs_n,
    input logic        ram_lo_cs_n
);
    assert_req_complement_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_n != io_req_n);

    assert_rom_only_on_window_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_cs_n |-> (cpu_wr_n && (&cpu_addr[15:13]) && !mem_req_n));

    assert_window_write_hits_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cpu_addr[15:13]) && !cpu_wr_n && !mem_req_n) |-> !ram_hi_cs_n);

    assert_low_ram_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_lo_cs_n |-> (!cpu_addr[15] && !mem_req_n));

    assert_bank_clear_hides_rom_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we && !bank_wdata) |=> rom_cs_n);

    assert_single_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!rom_cs_n, !ram_hi_cs_n, !ram_lo_cs_n}) <= 1);

    assert_io_blocks_selects_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !io_req_n |-> (rom_cs_n && ram_hi_cs_n && ram_lo_cs_n));
endmodule

bind rom_overlay_decoder rom_overlay_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_wr_n   (cpu_wr_n),
    .bank_we    (bank_we),
    .bank_wdata (bank_wdata),
    .io_req_n   (io_req_n),
    .mem_req_n  (mem_req_n),
    .rom_cs_n   (rom_cs_n),
    .ram_hi_cs_n(ram_hi_cs_n),
    .ram_lo_cs_n(ram_lo_cs_n)
);

// File: tb/rom_overlay_decoder_tb.sv
module rom_overlay_decoder_tb;
    localparam logic [7:0] PAGE_A = 8'h60;   // default instance
    localparam logic [7:0] PAGE_B = 8'hF8;   // I/O page inside the ROM window

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_wr_n = 1'b1;
    logic        bank_we = 1'b0;
    logic        bank_wdata = 1'b1;

    logic io_a, mem_a, rom_a, hi_a, lo_a;
    logic io_b, mem_b, rom_b, hi_b, lo_b;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rom_overlay_decoder #(.IO_PAGE(PAGE_A)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr_n(cpu_wr_n),
        .bank_we(bank_we), .bank_wdata(bank_wdata),
        .io_req_n(io_a), .mem_req_n(mem_a), .rom_cs_n(rom_a),
        .ram_hi_cs_n(hi_a), .ram_lo_cs_n(lo_a)
    );

    rom_overlay_decoder #(.IO_PAGE(PAGE_B)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr_n(cpu_wr_n),
        .bank_we(bank_we), .bank_wdata(bank_wdata),
        .io_req_n(io_b), .mem_req_n(mem_b), .rom_cs_n(rom_b),
        .ram_hi_cs_n(hi_b), .ram_lo_cs_n(lo_b)
    );

    // Expected outputs packed as {io_n, mem_n, rom_n, hi_n, lo_n}.
    function automatic logic [4:0] expect_out(input logic [15:0] a, input logic wr_n,
                                              input logic bank, input logic [7:0] iop);
        logic io, rom, hi, lo;
        io  = (a[15:8] == iop);
        rom = !io && (a[15:13] == 3'b111) && wr_n && bank;
        hi  = !io && a[15] && !rom;
        lo  = !io && !a[15];
        return {!io, io, !rom, !hi, !lo};
    endfunction

    task automatic check_vec(input string req, input logic [4:0] got, input logic [4:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s addr=%h wr_n=%b got=%b expected=%b", req, cpu_addr, cpu_wr_n, got, exp);
        end
    endtask

    task automatic write_bank(input logic v);
        @(negedge clk);
        bank_we = 1'b1;
        bank_wdata = v;
        @(negedge clk);
        bank_we = 1'b0;
        bank_wdata = ~v;   // opposite value while not enabled: must be ignored (R6)
    endtask

    task automatic sweep(input logic bank);
        for (int p = 0; p < 256; p++) begin
            for (int w = 0; w < 2; w++) begin
                @(negedge clk);
                cpu_addr = {p[7:0], p[7:0] ^ 8'h5A};
                cpu_wr_n = w[0];
                #1;
                // R1 R2 R3 R4: full decode against the reference
                check_vec("R1/R2/R3/R4", {io_a, mem_a, rom_a, hi_a, lo_a},
                          expect_out(cpu_addr, cpu_wr_n, bank, PAGE_A));
                // R8: I/O page inside the ROM window takes priority
                check_vec("R8", {io_b, mem_b, rom_b, hi_b, lo_b},
                          expect_out(cpu_addr, cpu_wr_n, bank, PAGE_B));
                // R7: at most one select
                checks++;
                if ((int'(!rom_a) + int'(!hi_a) + int'(!lo_a)) > 1 ||
                    (int'(!rom_b) + int'(!hi_b) + int'(!lo_b)) > 1) begin
                    errors++;
                    $display("FAIL R7 addr=%h got=%b%b%b/%b%b%b expected at most one low",
                             cpu_addr, rom_a, hi_a, lo_a, rom_b, hi_b, lo_b);
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R5: reset state makes the ROM visible, checked during and after reset
        cpu_addr = 16'hE000;
        cpu_wr_n = 1'b1;
        #1;
        check_vec("R5", {io_a, mem_a, rom_a, hi_a, lo_a}, 5'b10011);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check_vec("R5", {io_a, mem_a, rom_a, hi_a, lo_a}, 5'b10011);

        bank_wdata = 1'b0;   // not enabled: must not clear the bit (R6)
        repeat (2) @(negedge clk);
        #1;
        check_vec("R6", {io_a, mem_a, rom_a, hi_a, lo_a}, 5'b10011);

        sweep(1'b1);
        write_bank(1'b0);
        // R6: read of the top window now selects the upper RAM
        cpu_addr = 16'hFFFC;
        cpu_wr_n = 1'b1;
        #1;
        check_vec("R6", {io_a, mem_a, rom_a, hi_a, lo_a}, 5'b10101);
        sweep(1'b0);
        write_bank(1'b1);
        cpu_addr = 16'hE123;
        cpu_wr_n = 1'b1;
        #1;
        check_vec("R6", {io_a, mem_a, rom_a, hi_a, lo_a}, 5'b10011);
        // R3: a write to the same address goes to the RAM under the ROM
        cpu_wr_n = 1'b0;
        #1;
        check_vec("R3", {io_a, mem_a, rom_a, hi_a, lo_a}, 5'b10101);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired got=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule